// File: doc/BRIEF.md
# Nine-bit address character detector

This block sits beside the receive FIFO of a UART running a multidrop protocol with 9-bit characters. In such a protocol the ninth bit marks a character as an address. The receiver raises a strobe in the cycle that each assembled 9-bit character is pushed into the FIFO. The block samples the character on that strobe and can raise two interrupt requests. The first reports any character whose ninth bit is set. The second reports a character that equals one of four programmed 9-bit patterns, and comes with the number of the pattern that matched.

Software programs the block through a small byte-wide register port. A mode register holds the 9-bit enable, the enable for the any-address interrupt, and the ninth bits of the four patterns. A control register holds an enhanced-feature enable and the enable for the match interrupt. A status register shows the two pending requests and clears them on a write of one. Four pattern registers hold the low bytes of the patterns. Each request line stays high until software clears it.

Top module: `nine_bit_addr_det`

## Requirements
- R1: Reset clears every register, both request lines and the match index. All registers read 0 after reset.
- R2: The mode register is at address 0. Bits 7:6 always read as 0, whatever value was written.
- R3: While mode bit 0 (the 9-bit enable) is 0, no received character raises either request.
- R4: When mode bits 0 and 1 are both 1, a pushed character with bit 8 set raises `addr_irq_o` one cycle after the push. A character with bit 8 clear does not raise it.
- R5: A match raises `match_irq_o` only if mode bit 0 is 1 and control register bits 0 (enhanced) and 1 (match enable) are both 1. The control register is at address 1.
- R6: Pattern n (n = 0..3) is the 9-bit value {mode bit 2+n, register at address 4+n}. A match requires all nine bits to be equal, so a character with bit 8 clear never matches a pattern whose ninth bit is 1.
- R7: When a character equals several patterns, `match_idx_o` reports the lowest-numbered one. The index is loaded one cycle after the matching push and holds until the next match.
- R8: A character is evaluated only in a cycle where `rx_push_i` is high. Character data presented without the strobe has no effect.
- R9: The status register is at address 2. Bit 0 shows the pending address request and bit 1 shows the pending match request. Writing 1 to a bit clears that bit, and writing 0 leaves it unchanged.
- R10: If a new event and a clear of the same request fall in the same cycle, the request stays pending.
- R11: A pending request stays asserted while no clear is written, even when no further characters arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Read data for `addr_i`, combinational |
| rx_push_i | input | 1 | Strobe: a received character enters the FIFO |
| rx_char_i | input | 9 | The received 9-bit character |
| addr_irq_o | output | 1 | Pending request for an address character |
| match_irq_o | output | 1 | Pending request for a pattern match |
| match_idx_o | output | 2 | Number of the last matched pattern |

## Verification
A write-one-to-clear to the status register and a new event for the same request can fall in the same clock cycle. The bench provokes this by raising the receive strobe and writing the status register in a single cycle. It does so once with an address character against a pending address request, and once with a matching character against a pending match request while clearing only the match bit. After that edge the bench expects the request that received the new event to stay high, and any request that was only cleared to drop.

// File: rtl/nbad_pkg.sv
package nbad_pkg;
  localparam int NUM_PAT = 4;
  localparam int IDX_W   = $clog2(NUM_PAT);
  localparam int BYTE_W  = 8;
  localparam int CHAR_W  = BYTE_W + 1;
  localparam int ADDR_W  = 3;

  typedef logic [BYTE_W-1:0] byte_t;

  localparam logic [ADDR_W-1:0] A_MODE = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd1;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd2;

  // mode register fields
  localparam int M_EN      = 0;
  localparam int M_ADDR_IE = 1;
  localparam int M_HI_LSB  = 2;
  localparam int M_USED    = M_HI_LSB + NUM_PAT;

  // control register fields
  localparam int C_ENH      = 0;
  localparam int C_MATCH_IE = 1;
  localparam int C_W        = 2;

  // status / source index
  localparam int S_ADDR = 0;
  localparam int S_MATCH = 1;
  localparam int NUM_SRC = 2;
endpackage

// File: rtl/nbad_regs.sv
module nbad_regs
  import nbad_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  byte_t              wdata_i,
  input  logic [NUM_SRC-1:0] pend_i,
  output byte_t              mode_o,
  output logic [C_W-1:0]     ctrl_o,
  output byte_t              pat_lo_o [NUM_PAT],
  output logic [NUM_SRC-1:0] clr_o,
  output byte_t              rdata_o
);
  logic [M_USED-1:0] mode_q;
  logic [C_W-1:0]    ctrl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      ctrl_q <= '0;
    end else if (wr_en_i) begin
      if (addr_i == A_MODE) mode_q <= wdata_i[M_USED-1:0];
      if (addr_i == A_CTRL) ctrl_q <= wdata_i[C_W-1:0];
    end
  end

  for (genvar g = 0; g < NUM_PAT; g++) begin : g_pat
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pat_lo_o[g] <= '0;
      else if (wr_en_i && addr_i[ADDR_W-1] && (addr_i[IDX_W-1:0] == IDX_W'(g)))
        pat_lo_o[g] <= wdata_i;
    end
  end

  assign mode_o = {{(BYTE_W-M_USED){1'b0}}, mode_q};
  assign ctrl_o = ctrl_q;
  assign clr_o  = (wr_en_i && addr_i == A_STAT) ? wdata_i[NUM_SRC-1:0] : '0;

  always_comb begin
    rdata_o = '0;
    if (addr_i[ADDR_W-1])         rdata_o = pat_lo_o[addr_i[IDX_W-1:0]];
    else if (addr_i == A_MODE)    rdata_o = mode_o;
    else if (addr_i == A_CTRL)    rdata_o = {{(BYTE_W-C_W){1'b0}}, ctrl_q};
    else if (addr_i == A_STAT)    rdata_o = {{(BYTE_W-NUM_SRC){1'b0}}, pend_i};
  end

  p_rsvd_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == A_MODE) |-> (rdata_o[BYTE_W-1:M_USED] == '0));
endmodule

// File: rtl/nbad_match.sv
module nbad_match
  import nbad_pkg::*;
(
  input  logic [CHAR_W-1:0]  char_i,
  input  byte_t              pat_lo_i [NUM_PAT],
  input  logic [NUM_PAT-1:0] pat_hi_i,
  output logic               hit_o,
  output logic [IDX_W-1:0]   idx_o
);
  logic [NUM_PAT-1:0] hit;

  for (genvar g = 0; g < NUM_PAT; g++) begin : g_cmp
    assign hit[g] = (char_i == {pat_hi_i[g], pat_lo_i[g]});
  end

  // lowest index wins: scan downward so the last assignment is the lowest hit
  always_comb begin
    idx_o = '0;
    for (int i = NUM_PAT - 1; i >= 0; i--)
      if (hit[i]) idx_o = IDX_W'(i);
  end

  assign hit_o = |hit;

  always_comb begin
    if (hit_o === 1'b1) begin
      p_lowest_hit_r7: assert (hit[idx_o] &&
        ((hit & ((NUM_PAT'(1) << idx_o) - NUM_PAT'(1))) == '0));
    end
  end
endmodule

// File: rtl/nbad_pend.sv
module nbad_pend (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic pend_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pend_o <= 1'b0;
    else if (set_i)  pend_o <= 1'b1;
    else if (clr_i)  pend_o <= 1'b0;
  end

  p_set_wins_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> pend_o);
  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_o && !clr_i) |=> pend_o);
  p_w1c_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !set_i) |=> !pend_o);
endmodule

// File: rtl/nine_bit_addr_det.sv
module nine_bit_addr_det
  import nbad_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [2:0]        addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  input  logic              rx_push_i,
  input  logic [8:0]        rx_char_i,
  output logic              addr_irq_o,
  output logic              match_irq_o,
  output logic [1:0]        match_idx_o
);
  byte_t              mode;
  logic [C_W-1:0]     ctrl;
  byte_t              pat_lo [NUM_PAT];
  logic [NUM_SRC-1:0] clr, set, pend;
  logic               hit;
  logic [IDX_W-1:0]   hit_idx, idx_q;
  logic               match_on;

  nbad_regs u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .pend_i   (pend),
    .mode_o   (mode),
    .ctrl_o   (ctrl),
    .pat_lo_o (pat_lo),
    .clr_o    (clr),
    .rdata_o
  );

  nbad_match u_match (
    .char_i   (rx_char_i),
    .pat_lo_i (pat_lo),
    .pat_hi_i (mode[M_HI_LSB +: NUM_PAT]),
    .hit_o    (hit),
    .idx_o    (hit_idx)
  );

  assign match_on       = mode[M_EN] && ctrl[C_ENH] && ctrl[C_MATCH_IE];
  assign set[S_ADDR]    = rx_push_i && mode[M_EN] && mode[M_ADDR_IE] && rx_char_i[CHAR_W-1];
  assign set[S_MATCH]   = rx_push_i && match_on && hit;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    nbad_pend u_pend (
      .clk_i, .rst_ni,
      .set_i  (set[s]),
      .clr_i  (clr[s]),
      .pend_o (pend[s])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            idx_q <= '0;
    else if (set[S_MATCH])  idx_q <= hit_idx;
  end

  assign addr_irq_o  = pend[S_ADDR];
  assign match_irq_o = pend[S_MATCH];
  assign match_idx_o = idx_q;

  p_addr_src_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(addr_irq_o) |-> $past(mode[M_EN] && rx_push_i && rx_char_i[CHAR_W-1]));
  p_match_gate_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(match_irq_o) |-> $past(mode[M_EN] && ctrl == 2'b11 && rx_push_i));
  p_idx_stable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_push_i |=> $stable(match_idx_o));
endmodule

// File: tb/nine_bit_addr_det_tb_top.sv
`timescale 1ns/1ps
module nine_bit_addr_det_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       push = 1'b0;
  logic [8:0] ch = '0;
  logic       a_irq, m_irq;
  logic [1:0] idx;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  nine_bit_addr_det dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .rx_push_i(push), .rx_char_i(ch),
    .addr_irq_o(a_irq), .match_irq_o(m_irq), .match_idx_o(idx)
  );

  // {char[8:0], exp_addr, exp_match, exp_idx[1:0]}
  // patterns: p0=1_41 p1=0_41 p2=1_7E p3=0_41
  localparam logic [12:0] VEC [7] = '{
    {9'h141, 1'b1, 1'b1, 2'd0},
    {9'h041, 1'b0, 1'b1, 2'd1},
    {9'h17E, 1'b1, 1'b1, 2'd2},
    {9'h07E, 1'b0, 1'b0, 2'd2},
    {9'h155, 1'b1, 1'b0, 2'd2},
    {9'h055, 1'b0, 1'b0, 2'd2},
    {9'h0C1, 1'b0, 1'b0, 2'd2}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic rx(input logic [8:0] c);
    @(negedge clk); push = 1'b1; ch = c;
    @(negedge clk); push = 1'b0;
  endtask

  task automatic rx_clr(input logic [8:0] c, input logic [1:0] w);
    @(negedge clk); push = 1'b1; ch = c; wr_en = 1'b1; addr = 3'd2; wdata = {6'd0, w};
    @(negedge clk); push = 1'b0; wr_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk(!a_irq && !m_irq && idx == 0, "R1 outputs", {a_irq, m_irq, idx}, 0);
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      chk(d == 0, "R1 register", d, 0);
    end

    // R2 reserved bits
    wr(3'd0, 8'hFF);
    rd(3'd0, d);
    chk(d == 8'h3F, "R2 mode readback", d, 8'h3F);

    // configure
    wr(3'd0, 8'h17);
    wr(3'd1, 8'h03);
    wr(3'd4, 8'h41);
    wr(3'd5, 8'h41);
    wr(3'd6, 8'h7E);
    wr(3'd7, 8'h41);
    rd(3'd6, d);
    chk(d == 8'h7E, "R6 pattern readback", d, 8'h7E);

    // table: R4, R6, R7, R9
    for (int v = 0; v < 7; v++) begin
      rx(VEC[v][12:4]);
      chk(a_irq == VEC[v][3], "R4 address request", a_irq, VEC[v][3]);
      chk(m_irq == VEC[v][2], "R6 match request", m_irq, VEC[v][2]);
      chk(idx == VEC[v][1:0], "R7 match index", idx, VEC[v][1:0]);
      wr(3'd2, 8'h03);
      chk(!a_irq && !m_irq, "R9 clear both", {a_irq, m_irq}, 0);
    end

    // R11 hold, R9 status view
    rx(9'h155);
    repeat (4) @(negedge clk);
    chk(a_irq, "R11 hold", a_irq, 1);
    rd(3'd2, d);
    chk(d == 8'h01, "R9 status read", d, 1);
    wr(3'd2, 8'h00);
    chk(a_irq, "R9 write zero keeps", a_irq, 1);

    // R10 set and clear in one cycle
    rx_clr(9'h155, 2'b01);
    chk(a_irq, "R10 address set wins", a_irq, 1);
    wr(3'd2, 8'h03);
    rx(9'h17E);
    rx_clr(9'h141, 2'b10);
    chk(m_irq, "R10 match set wins", m_irq, 1);
    chk(a_irq, "R10 other kept", a_irq, 1);
    chk(idx == 0, "R10 index", idx, 0);
    rx_clr(9'h055, 2'b11);
    chk(!a_irq && !m_irq, "R10 plain clear", {a_irq, m_irq}, 0);

    // R8 data without strobe
    @(negedge clk); ch = 9'h17E;
    repeat (5) @(negedge clk);
    chk(!a_irq && !m_irq && idx == 0, "R8 no strobe", {a_irq, m_irq, idx}, 0);

    // R5 gating
    wr(3'd1, 8'h02);
    rx(9'h17E);
    chk(!m_irq, "R5 enhanced off", m_irq, 0);
    chk(a_irq, "R5 address unaffected", a_irq, 1);
    wr(3'd1, 8'h01);
    rx(9'h17E);
    chk(!m_irq, "R5 match enable off", m_irq, 0);
    chk(idx == 0, "R5 index held", idx, 0);
    wr(3'd1, 8'h03);
    wr(3'd2, 8'h03);

    // R3 9-bit mode off
    wr(3'd0, 8'h16);
    rx(9'h141);
    rx(9'h17E);
    chk(!a_irq && !m_irq, "R3 disabled", {a_irq, m_irq}, 0);
    wr(3'd0, 8'h17);

    // R6 highest pattern, R7 index 3
    wr(3'd7, 8'h99);
    rx(9'h099);
    chk(m_irq && idx == 3, "R7 index three", idx, 3);
    chk(!a_irq, "R4 ninth bit clear", a_irq, 0);
    wr(3'd2, 8'h02);
    rx(9'h199);
    chk(!m_irq, "R6 ninth bit mismatch", m_irq, 0);
    chk(a_irq, "R4 ninth bit set", a_irq, 1);

    // R1 reset with pending
    rx(9'h141);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk(!a_irq && !m_irq && idx == 0, "R1 reset clears", {a_irq, m_irq, idx}, 0);
    rd(3'd0, d);
    chk(d == 0, "R1 mode cleared", d, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule